// File: doc/BRIEF.md
# Sub-second alarm masked comparator

This block decides when a sub-second alarm fires. It holds a programmed 15-bit sub-second target and a 4-bit mask count. Each clock it compares the low-order bits that the mask selects against the running count of a synchronous prescaler. When the mask count is zero, no sub-second bits are compared. In that case the trigger is the pulse that marks a seconds increment.

The comparison result is combined with an alarm enable and an external indication that the remaining calendar fields match. The first cycle of a match sets a sticky alarm flag, which software clears through the register bus.

The alarm register is guarded in two ways.
- A two-key write-protection sequence must be completed first.
- The alarm must be disabled, or the block must be in initialization mode.

A refused write leaves the register as it was and returns a one-cycle error pulse.

Top module: `subsec_alarm_cmp`

## Requirements
- R1: Address 0 reads the sub-second target in bits 14:0 and the mask count in bits 27:24; every other bit reads zero, and writes to it have no effect. Address 3 reads zero and ignores writes, and address 1 reads zero.
- R2: With mask count N in 1..14, a match needs only count bits N-1..0 equal to the target. Count bit 15, the overflow bit, is never compared.
- R3: With mask count 15, all 15 count bits 14:0 must equal the target.
- R4: With mask count 0, the target value is ignored and the trigger is `sec_inc_i`.
- R5: A trigger counts only while `alarm_en_i` = 1 and `fields_match_i` = 1.
- R6: `alarm_flag_o` rises one clock after the first cycle of a trigger and stays high until a write of bit 0 = 1 to address 2. A trigger that persists does not set the flag again after it is cleared, and a set in the same cycle as a clear wins. Bit 0 of address 2 reads the flag.
- R7: Reset leaves the alarm register locked. Writing 0xCA and then 0x53 to the low byte of address 1 unlocks it. Any other key value locks it again, and 0xCA always restarts the sequence.
- R8: A write to address 0 takes effect only while the register is unlocked and (`alarm_en_i` = 0 or `init_mode_i` = 1). Otherwise the register is unchanged and `bus_err_o` is high for exactly the next cycle.
- R9: After reset the alarm register, the flag and `bus_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational on the address) |
| bus_err_o | output | 1 | One-cycle pulse after a refused alarm-register write |
| alarm_en_i | input | 1 | Alarm enable |
| init_mode_i | input | 1 | Initialization mode |
| ss_cnt_i | input | 16 | Prescaler sub-second count; bit 15 is the overflow bit |
| sec_inc_i | input | 1 | Seconds-increment pulse |
| fields_match_i | input | 1 | The other alarm fields match |
| alarm_flag_o | output | 1 | Sticky alarm flag |

## Verification
Read data is combinational: it is due in the same cycle as the address, and it reflects the writes taken at earlier edges. The error pulse and the flag each come from a single register, so they are due one clock after the write, or after the first trigger cycle. The bench drives its inputs 1 ns after the falling edge. It compares a behavioural model with every output at the falling edge, before any input changes. Its directed checks read outputs in the cycle that follows the edge that captured the stimulus.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  parameter int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_ALARM = 2'd0,
    A_KEY   = 2'd1,
    A_FLAG  = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_KEY1   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;
endpackage

// File: rtl/ssa_mask_dec.sv
module ssa_mask_dec #(
  parameter int unsigned SS_W   = 15,
  parameter int unsigned MASK_W = 4
) (
  input  logic [MASK_W-1:0] mask_i,
  output logic [SS_W-1:0]   cmp_mask_o
);
  // bit i takes part in the compare when i < N
  for (genvar i = 0; i < SS_W; i++) begin : g_bit
    assign cmp_mask_o[i] = ({1'b0, mask_i} > (MASK_W+1)'(i));
  end
endmodule

// File: rtl/ssa_wprot.sv
module ssa_wprot
  import ssa_pkg::*;
#(
  parameter int unsigned KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_A = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_B = 8'h53
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             open_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr_i) begin
      if (key_i == KEY_A)                               state_d = LK_KEY1;
      else if (key_i == KEY_B && state_q == LK_KEY1)    state_d = LK_OPEN;
      else                                              state_d = LK_LOCKED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == LK_OPEN);
endmodule

// File: rtl/ssa_match.sv
module ssa_match #(
  parameter int unsigned SS_W = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alarm_en_i,
  input  logic            fields_match_i,
  input  logic            sec_inc_i,
  input  logic            use_sec_i,
  input  logic [SS_W-1:0] ss_ref_i,
  input  logic [SS_W:0]   ss_cnt_i,
  input  logic [SS_W-1:0] cmp_mask_i,
  input  logic            flag_clr_i,
  output logic            flag_o
);
  logic ss_eq, raw_hit, hit_q, hit_evt;

  // overflow bit ss_cnt_i[SS_W] deliberately left out
  assign ss_eq   = ((ss_cnt_i[SS_W-1:0] ^ ss_ref_i) & cmp_mask_i) == '0;
  assign raw_hit = alarm_en_i && fields_match_i && (use_sec_i ? sec_inc_i : ss_eq);
  assign hit_evt = raw_hit && !hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      hit_q  <= raw_hit;
      flag_o <= hit_evt || (flag_o && !flag_clr_i);
    end
  end
endmodule

// File: rtl/subsec_alarm_cmp.sv
module subsec_alarm_cmp
  import ssa_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SS_W     = 15,
  parameter int unsigned MASK_W   = 4,
  parameter int unsigned MASK_LSB = 24,
  parameter int unsigned KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_A = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_B = 8'h53
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_wr_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  bus_err_o,
  input  logic                  alarm_en_i,
  input  logic                  init_mode_i,
  input  logic [SS_W:0]         ss_cnt_i,
  input  logic                  sec_inc_i,
  input  logic                  fields_match_i,
  output logic                  alarm_flag_o
);
  localparam int unsigned MASK_MSB = MASK_LSB + MASK_W - 1;

  reg_addr_e         addr;
  logic              wr_alarm, wr_key, wr_flag, flag_clr;
  logic              unlocked, cfg_ok, wr_ok, wr_block;
  logic [SS_W-1:0]   ss_q, cmp_mask;
  logic [MASK_W-1:0] mask_q;

  assign addr     = reg_addr_e'(bus_addr_i);
  assign wr_alarm = bus_wr_i && (addr == A_ALARM);
  assign wr_key   = bus_wr_i && (addr == A_KEY);
  assign wr_flag  = bus_wr_i && (addr == A_FLAG);
  assign flag_clr = wr_flag && bus_wdata_i[0];

  ssa_wprot #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_wprot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (wr_key),
    .key_i    (bus_wdata_i[KEY_W-1:0]),
    .open_o   (unlocked)
  );

  assign cfg_ok   = !alarm_en_i || init_mode_i;
  assign wr_ok    = wr_alarm && unlocked && cfg_ok;
  assign wr_block = wr_alarm && !wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_q      <= '0;
      mask_q    <= '0;
      bus_err_o <= 1'b0;
    end else begin
      bus_err_o <= wr_block;
      if (wr_ok) begin
        ss_q   <= bus_wdata_i[SS_W-1:0];
        mask_q <= bus_wdata_i[MASK_MSB:MASK_LSB];
      end
    end
  end

  ssa_mask_dec #(.SS_W(SS_W), .MASK_W(MASK_W)) u_mask_dec (
    .mask_i     (mask_q),
    .cmp_mask_o (cmp_mask)
  );

  ssa_match #(.SS_W(SS_W)) u_match (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alarm_en_i     (alarm_en_i),
    .fields_match_i (fields_match_i),
    .sec_inc_i      (sec_inc_i),
    .use_sec_i      (mask_q == '0),
    .ss_ref_i       (ss_q),
    .ss_cnt_i       (ss_cnt_i),
    .cmp_mask_i     (cmp_mask),
    .flag_clr_i     (flag_clr),
    .flag_o         (alarm_flag_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (addr)
      A_ALARM: begin
        bus_rdata_o[SS_W-1:0]          = ss_q;
        bus_rdata_o[MASK_MSB:MASK_LSB] = mask_q;
      end
      A_FLAG:  bus_rdata_o[0] = alarm_flag_o;
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ssa_chk.sv
module ssa_chk
  import ssa_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SS_W     = 15,
  parameter int unsigned MASK_W   = 4,
  parameter int unsigned MASK_LSB = 24,
  parameter int unsigned KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_B = 8'h53
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_wr_i,
  input logic [REG_ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0]     bus_wdata_i,
  input logic [DATA_W-1:0]     bus_rdata_o,
  input logic                  bus_err_o,
  input logic                  alarm_en_i,
  input logic                  fields_match_i,
  input logic                  sec_inc_i,
  input logic                  alarm_flag_o,
  input logic                  wr_ok_i,
  input logic                  unlocked_i,
  input logic [SS_W-1:0]       ss_q_i,
  input logic [MASK_W-1:0]     mask_q_i
);
  localparam int unsigned HI_LSB = MASK_LSB + MASK_W;

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> $past(bus_wr_i && bus_addr_i == A_ALARM)); // R8

  AST_BLOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_ALARM && !wr_ok_i)
      |=> (bus_err_o && $stable(ss_q_i) && $stable(mask_q_i))); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == A_ALARM)
      |-> (bus_rdata_o[DATA_W-1:HI_LSB] == '0 && bus_rdata_o[MASK_LSB-1:SS_W] == '0)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_flag_o && !(bus_wr_i && bus_addr_i == A_FLAG && bus_wdata_i[0]))
      |=> alarm_flag_o); // R6

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag_o) |-> $past(alarm_en_i && fields_match_i)); // R5

  AST_MASK0_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(alarm_flag_o) && $past(mask_q_i) == '0) |-> $past(sec_inc_i)); // R4

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_i)
      |-> $past(bus_wr_i && bus_addr_i == A_KEY && bus_wdata_i[KEY_W-1:0] == KEY_B)); // R7
endmodule

bind subsec_alarm_cmp ssa_chk #(
  .DATA_W(DATA_W), .SS_W(SS_W), .MASK_W(MASK_W), .MASK_LSB(MASK_LSB),
  .KEY_W(KEY_W), .KEY_B(KEY_B)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bus_wr_i       (bus_wr_i),
  .bus_addr_i     (bus_addr_i),
  .bus_wdata_i    (bus_wdata_i),
  .bus_rdata_o    (bus_rdata_o),
  .bus_err_o      (bus_err_o),
  .alarm_en_i     (alarm_en_i),
  .fields_match_i (fields_match_i),
  .sec_inc_i      (sec_inc_i),
  .alarm_flag_o   (alarm_flag_o),
  .wr_ok_i        (wr_ok),
  .unlocked_i     (unlocked),
  .ss_q_i         (ss_q),
  .mask_q_i       (mask_q)
);

// File: tb/subsec_alarm_cmp_bench.sv
`timescale 1ns/1ps
module subsec_alarm_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        alarm_en = 1'b0, init_mode = 1'b0, sec_inc = 1'b0, fmatch = 1'b0;
  logic [15:0] ss_cnt = '0;
  logic        alarm_flag;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  subsec_alarm_cmp u_subsec_alarm_cmp (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_err_o(bus_err),
    .alarm_en_i(alarm_en), .init_mode_i(init_mode), .ss_cnt_i(ss_cnt),
    .sec_inc_i(sec_inc), .fields_match_i(fmatch), .alarm_flag_o(alarm_flag)
  );

  // behavioural reference model
  int         m_ss, m_mask, m_lock;
  bit         m_flag, m_err, m_hitq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ss = 0; m_mask = 0; m_lock = 0; m_flag = 0; m_err = 0; m_hitq = 0;
    end else begin
      bit eq, hit, evt;
      eq = 1;
      for (int i = 0; i < m_mask; i++) if (ss_cnt[i] != ((m_ss >> i) & 1)) eq = 0;
      hit = alarm_en && fmatch && ((m_mask == 0) ? sec_inc : eq);
      evt = hit && !m_hitq;
      m_hitq = hit;
      if (evt) m_flag = 1;
      else if (bus_wr && bus_addr == 2 && bus_wdata[0]) m_flag = 0;
      m_err = 0;
      if (bus_wr && bus_addr == 0) begin
        if (m_lock == 2 && (!alarm_en || init_mode)) begin
          m_ss = bus_wdata & 32'h7FFF;
          m_mask = (bus_wdata >> 24) & 32'hF;
        end else m_err = 1;
      end
      if (bus_wr && bus_addr == 1) begin
        if (bus_wdata[7:0] == 8'hCA) m_lock = 1;
        else if (bus_wdata[7:0] == 8'h53 && m_lock == 1) m_lock = 2;
        else m_lock = 0;
      end
    end
  end

  function automatic logic [31:0] m_rdata(input logic [1:0] a);
    case (a)
      2'd0: return 32'(m_ss) | (32'(m_mask) << 24);
      2'd2: return {31'b0, m_flag};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, before any input changes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(alarm_flag === m_flag, "R6 flag vs model", 32'(alarm_flag), 32'(m_flag));
      chk(bus_err === m_err, "R8 err vs model", 32'(bus_err), 32'(m_err));
      chk(bus_rdata === m_rdata(bus_addr), "R1 rdata vs model", bus_rdata, m_rdata(bus_addr));
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic exp_flag(input bit e, input string tag);
    chk(alarm_flag === e, tag, 32'(alarm_flag), 32'(e));
  endtask

  task automatic exp_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v === e, tag, v, e);
  endtask

  task automatic unlock();
    wr(2'd1, 32'hCA); wr(2'd1, 32'h53);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    exp_reg(2'd0, 32'h0, "R9 reset alarm reg");
    exp_reg(2'd2, 32'h0, "R9 reset flag");
    chk(bus_err === 1'b0, "R9 reset err", 32'(bus_err), 0);

    // R7 locked after reset: write refused
    wr(2'd0, 32'h0300_0010);
    chk(bus_err === 1'b1, "R8 err on locked write", 32'(bus_err), 1);
    exp_reg(2'd0, 32'h0, "R7 locked write ignored");
    step();
    chk(bus_err === 1'b0, "R8 err one cycle", 32'(bus_err), 0);

    // R1 field layout, reserved bits
    unlock();
    wr(2'd0, 32'hF5FF_FFFF);
    chk(bus_err === 1'b0, "R8 no err when open", 32'(bus_err), 0);
    exp_reg(2'd0, 32'h0500_7FFF, "R1 readback layout");

    // R7 broken sequence relocks
    wr(2'd1, 32'hCA); wr(2'd1, 32'h12);
    wr(2'd0, 32'h0);
    chk(bus_err === 1'b1, "R7 bad key relocks", 32'(bus_err), 1);
    exp_reg(2'd0, 32'h0500_7FFF, "R7 value kept");

    // R2 mask 4
    unlock();
    wr(2'd0, 32'h0400_1234);
    alarm_en = 1; fmatch = 1; ss_cnt = 16'h0005;
    step(); step();
    exp_flag(0, "R2 low nibble differs");
    ss_cnt = 16'hFFF4; step();
    exp_flag(1, "R2 low nibble match, high and overflow ignored");

    // R6 clear while match persists, no retrigger
    wr(2'd2, 32'h1);
    exp_flag(0, "R6 clear");
    step(); step();
    exp_flag(0, "R6 persistent match no retrigger");
    ss_cnt = 16'h0; step();
    ss_cnt = 16'h0004; step();
    exp_flag(1, "R6 new match event sets");
    wr(2'd2, 32'h1);

    // R8 alarm enabled: init mode allows, otherwise blocked
    init_mode = 1; wr(2'd0, 32'h0F00_1234);
    chk(bus_err === 1'b0, "R8 init mode write ok", 32'(bus_err), 0);
    init_mode = 0; wr(2'd0, 32'h0);
    chk(bus_err === 1'b1, "R8 enabled write blocked", 32'(bus_err), 1);
    exp_reg(2'd0, 32'h0F00_1234, "R8 blocked write leaves reg");

    // R3 mask 15
    ss_cnt = 16'h5234; step(); step();
    exp_flag(0, "R3 bit14 differs");
    ss_cnt = 16'h1234; step();
    exp_flag(1, "R3 full match");
    wr(2'd2, 32'h1);

    // R5 gating
    fmatch = 0; ss_cnt = 16'h0; step();
    ss_cnt = 16'h1234; step(); step();
    exp_flag(0, "R5 fields mismatch blocks");
    fmatch = 1; step();
    exp_flag(1, "R5 fields match sets");
    wr(2'd2, 32'h1);
    alarm_en = 0; ss_cnt = 16'h0; step();
    ss_cnt = 16'h1234; step(); step();
    exp_flag(0, "R5 disabled blocks");

    // R4 mask 0
    wr(2'd0, 32'h0000_1234);
    alarm_en = 1; step(); step();
    exp_flag(0, "R4 value ignored with mask 0");
    sec_inc = 1; step(); sec_inc = 0;
    exp_flag(1, "R4 seconds increment sets");
    wr(2'd2, 32'h1);
    fmatch = 0; sec_inc = 1; step(); sec_inc = 0; step();
    exp_flag(0, "R5 seconds pulse without field match");
    fmatch = 1; sec_inc = 1;
    wr(2'd2, 32'h1); sec_inc = 0;
    exp_flag(1, "R6 set wins over clear");
    wr(2'd2, 32'h1);

    // R1 unused addresses
    wr(2'd3, 32'hFFFF_FFFF);
    exp_reg(2'd3, 32'h0, "R1 address 3 reads zero");
    exp_reg(2'd1, 32'h0, "R1 key address reads zero");

    // random phase, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      bus_wr = (r < 4);
      bus_addr = 2'($urandom_range(0, 3));
      bus_wdata = $urandom;
      if (bus_addr == 2'd1) bus_wdata[7:0] = (r == 0) ? 8'hCA : (r == 1 ? 8'h53 : bus_wdata[7:0]);
      if (bus_addr == 2'd0) bus_wdata[14:4] = '0;
      alarm_en = ($urandom_range(0, 3) != 0);
      init_mode = ($urandom_range(0, 3) == 0);
      fmatch = ($urandom_range(0, 3) != 0);
      sec_inc = ($urandom_range(0, 7) == 0);
      ss_cnt = 16'($urandom_range(0, 31)) | (16'($urandom_range(0, 1)) << 15);
      step();
    end
    bus_wr = 0;
    step();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule